// File: doc/BRIEF.md
# Instruction Cycle Timing Controller

This block turns the oscillator clock of a small 8-bit controller core with 13-bit instruction words into instruction cycles. A configuration input chooses the cycle length: two oscillator periods or four. The block samples that input once, on the first clock after reset. Inside each cycle a phase counter runs from 0 up to the last phase. On the last phase the block raises a one-clock fetch enable and a one-clock enable for the timer/counter prescaler. Because the timer enable comes once per instruction cycle, the timer runs at Fosc/2 in two-period mode and at Fosc/4 in four-period mode.

The instruction decoder supplies five class flags: jump, call, return, skip with a true test, and program-counter write. If any flag is high when the first phase of a normal cycle ends, one extra instruction cycle follows the current one. During that extra cycle the stall output is high and no fetch enable is given, so the core treats the word already fetched as a no-operation. Several flags raised together still add only one extra cycle. Flags seen at any other time are ignored.

Top module: `instr_cycle_timer`

## Requirements
- R1: While reset is low, and on the first clock after reset is released, phase_o is 0 and stall_o, fetch_en_o and tmr_en_o are low.
- R2: When cyc4_cfg_i is low at the first clock after reset, phase_o counts 0,1,0,1 and a flag-free instruction cycle lasts 2 clocks.
- R3: When cyc4_cfg_i is high at the first clock after reset, phase_o counts 0,1,2,3 and a flag-free instruction cycle lasts 4 clocks.
- R4: tmr_en_o is high for exactly one clock on the last phase of every instruction cycle, stalled cycles included. This gives one pulse per 2 clocks in two-period mode and one per 4 clocks in four-period mode.
- R5: fetch_en_o is high for one clock on the last phase of each non-stalled instruction cycle, and never while stall_o is high.
- R6: A jump, call or return flag adds one stalled instruction cycle, which doubles the total length of the instruction (4 clocks in two-period mode, 8 in four-period mode).
- R7: A skip whose test was true (skip_i high) adds one stalled cycle. A skip whose test was false leaves skip_i low and adds nothing.
- R8: A program-counter write flag adds one stalled cycle.
- R9: Any combination of several flags raised together adds exactly one stalled cycle.
- R10: Flags are sampled only at the end of phase 0 of a non-stalled cycle. Flags present only in later phases, or during a stalled cycle, have no effect.
- R11: cyc4_cfg_i is captured on the first clock after reset. Later changes have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc4_cfg_i | input | 1 | Cycle length select: 0 = two periods, 1 = four periods |
| jmp_i | input | 1 | Jump instruction in the current cycle |
| call_i | input | 1 | Call instruction in the current cycle |
| ret_i | input | 1 | Return instruction (any return form) in the current cycle |
| skip_i | input | 1 | Conditional skip whose test was true |
| pc_wr_i | input | 1 | Instruction writes the program counter register |
| phase_o | output | 2 | Phase within the current instruction cycle |
| fetch_en_o | output | 1 | One-clock fetch enable on the last phase of a normal cycle |
| stall_o | output | 1 | High for the whole of an extra cycle; the fetched word becomes a no-operation |
| tmr_en_o | output | 1 | Timer/counter prescaler clock enable, one clock per instruction cycle |

## Verification
Flags sampled at the end of phase 0 affect stall_o only from the first clock of the next instruction cycle, one or three clocks later. Fetch and timer enables appear on the clock whose phase is the last one. The bench drives flags at the falling edge of a phase-0 clock and then counts falling edges until phase 0 of a normal cycle comes back. Over that window it counts the total clocks, the stall clocks, the fetch pulses and the timer pulses, so no check depends on the exact cycle of a single pulse. Startup is checked edge by edge: phase stays 0 on the first clock after reset and reaches 1 on the second.

// File: rtl/instr_cycle_timer_pkg.sv
package instr_cycle_timer_pkg;
  localparam int FAST_LEN  = 2;
  localparam int SLOW_LEN  = 4;
  localparam int PHW       = $clog2(SLOW_LEN);
  localparam int NUM_FLAGS = 5;

  typedef logic [PHW-1:0] phase_t;

  localparam phase_t FAST_LAST = phase_t'(FAST_LEN - 1);
  localparam phase_t SLOW_LAST = phase_t'(SLOW_LEN - 1);
endpackage

// File: rtl/ict_cfg_latch.sv
module ict_cfg_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_i,
  output logic slow_o,
  output logic run_o
);
  logic slow_q, run_q;

  // capture once, on the first clock out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_q <= 1'b0;
      run_q  <= 1'b0;
    end else if (!run_q) begin
      slow_q <= cfg_i;
      run_q  <= 1'b1;
    end
  end

  assign slow_o = slow_q;
  assign run_o  = run_q;
endmodule

// File: rtl/ict_phase_ctr.sv
module ict_phase_ctr
  import instr_cycle_timer_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  logic   slow_i,
  output phase_t phase_o,
  output logic   first_o,
  output logic   last_o
);
  phase_t phase_q;
  phase_t last_val;

  assign last_val = slow_i ? SLOW_LAST : FAST_LAST;
  assign last_o   = run_i && (phase_q == last_val);
  assign first_o  = run_i && (phase_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (last_o) phase_q <= '0;
    else if (run_i)  phase_q <= phase_q + 1'b1;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/ict_stall_ctl.sv
module ict_stall_ctl
  import instr_cycle_timer_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 first_i,
  input  logic                 last_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic                 stall_o
);
  logic pend_q, stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      if (first_i && !stall_q) pend_q <= |flags_i;
      else if (last_i)         pend_q <= 1'b0;
      if (last_i)              stall_q <= stall_q ? 1'b0 : pend_q;
    end
  end

  assign stall_o = stall_q;
endmodule

// File: rtl/instr_cycle_timer.sv
module instr_cycle_timer
  import instr_cycle_timer_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cyc4_cfg_i,
  input  logic           jmp_i,
  input  logic           call_i,
  input  logic           ret_i,
  input  logic           skip_i,
  input  logic           pc_wr_i,
  output logic [PHW-1:0] phase_o,
  output logic           fetch_en_o,
  output logic           stall_o,
  output logic           tmr_en_o
);
  logic                 cfg_slow, run_en;
  logic                 ph_first, ph_last;
  logic [NUM_FLAGS-1:0] flags;

  assign flags = {pc_wr_i, skip_i, ret_i, call_i, jmp_i};

  ict_cfg_latch u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cyc4_cfg_i),
    .slow_o (cfg_slow),
    .run_o  (run_en)
  );

  ict_phase_ctr u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_en),
    .slow_i  (cfg_slow),
    .phase_o (phase_o),
    .first_o (ph_first),
    .last_o  (ph_last)
  );

  ict_stall_ctl u_stall (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .first_i (ph_first),
    .last_i  (ph_last),
    .flags_i (flags),
    .stall_o (stall_o)
  );

  assign tmr_en_o   = ph_last;
  assign fetch_en_o = ph_last && !stall_o;
endmodule

// File: rtl/instr_cycle_timer_chk.sv
module instr_cycle_timer_chk
  import instr_cycle_timer_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           mode_i,
  input logic           run_i,
  input logic [PHW-1:0] phase_i,
  input logic           fetch_i,
  input logic           stall_i,
  input logic           tmr_i
);
  AST_IDLE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (phase_i == '0 && !stall_i && !tmr_i && !fetch_i)); // R1
  AST_FAST_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> (phase_i <= FAST_LAST)); // R2
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != '0) |-> (phase_i == PHW'($past(phase_i) + 1'b1))); // R3
  AST_TMR_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_i |=> !tmr_i); // R4
  AST_FETCH_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_i |-> (tmr_i && !stall_i)); // R5
  AST_STALL_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_i) |-> (phase_i == '0)); // R6
  AST_STALL_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_i) |-> (phase_i == '0)); // R9
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> $stable(mode_i)); // R11
endmodule

bind instr_cycle_timer instr_cycle_timer_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (cfg_slow),
  .run_i   (run_en),
  .phase_i (phase_o),
  .fetch_i (fetch_en_o),
  .stall_i (stall_o),
  .tmr_i   (tmr_en_o)
);

// File: tb/instr_cycle_timer_test.sv
module instr_cycle_timer_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg = 1'b0;
  logic [4:0] flg = '0;  // {pc_wr, skip, ret, call, jmp}
  logic [1:0] phase;
  logic       fetch_en, stall, tmr_en;
  int         errors = 0, checks = 0;
  logic       cur_mode = 1'b0;

  always #5 clk = ~clk;

  instr_cycle_timer uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .cyc4_cfg_i (cfg),
    .jmp_i      (flg[0]),
    .call_i     (flg[1]),
    .ret_i      (flg[2]),
    .skip_i     (flg[3]),
    .pc_wr_i    (flg[4]),
    .phase_o    (phase),
    .fetch_en_o (fetch_en),
    .stall_o    (stall),
    .tmr_en_o   (tmr_en)
  );

  typedef struct packed {
    logic       mode;
    logic [4:0] flags;
    logic       hold;
    logic [3:0] dly;
    logic [4:0] len;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'b00000, 1'b0, 4'd0, 5'd2},
    '{1'b0, 5'b00001, 1'b0, 4'd0, 5'd4},
    '{1'b0, 5'b00010, 1'b0, 4'd0, 5'd4},
    '{1'b0, 5'b00100, 1'b0, 4'd0, 5'd4},
    '{1'b0, 5'b01000, 1'b0, 4'd0, 5'd4},
    '{1'b0, 5'b10000, 1'b0, 4'd0, 5'd4},
    '{1'b0, 5'b10001, 1'b0, 4'd0, 5'd4},
    '{1'b0, 5'b11111, 1'b0, 4'd0, 5'd4},
    '{1'b0, 5'b00001, 1'b1, 4'd0, 5'd4},
    '{1'b1, 5'b00000, 1'b0, 4'd0, 5'd4},
    '{1'b1, 5'b00001, 1'b0, 4'd0, 5'd8},
    '{1'b1, 5'b01000, 1'b0, 4'd0, 5'd8},
    '{1'b1, 5'b10000, 1'b0, 4'd0, 5'd8},
    '{1'b1, 5'b01110, 1'b0, 4'd0, 5'd8},
    '{1'b1, 5'b00001, 1'b0, 4'd1, 5'd4},
    '{1'b1, 5'b00100, 1'b0, 4'd2, 5'd4},
    '{1'b1, 5'b00100, 1'b1, 4'd0, 5'd8}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(vec_t v);
    if (v.dly != 0 || v.hold) return "R10";
    if ($countones(v.flags) > 1) return "R9";
    if (v.flags[4]) return "R8";
    if (v.flags[3]) return "R7";
    if (|v.flags[2:0]) return "R6";
    return v.mode ? "R3" : "R2";
  endfunction

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_ni = 1'b0;
    cfg = mode;
    flg = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    cur_mode = mode;
  endtask

  task automatic run_vec(input vec_t v);
    int n = 0, st = 0, fe = 0, tm = 0;
    string t = tag_of(v);
    do @(negedge clk); while (!(phase == 2'd0 && !stall));
    if (v.dly == 0) flg = v.flags;
    do begin
      @(negedge clk);
      n++;
      if (stall) st++;
      if (fetch_en) fe++;
      if (tmr_en) tm++;
      if (n == int'(v.dly) && v.dly != 0) flg = v.flags;
      else if (!v.hold && n == int'(v.dly) + 1) flg = '0;
    end while (!(phase == 2'd0 && !stall) && n < 40);
    flg = '0;
    check(t, "cycle clocks", n, int'(v.len));
    check(t, "stall clocks", st, (int'(v.len) == (v.mode ? 8 : 4)) ? int'(v.len) / 2 : 0);
    check("R5", "fetch pulses", fe, 1);
    check("R4", "timer pulses", tm, int'(v.len) / (v.mode ? 4 : 2));
  endtask

  task automatic count_tmr(input int clocks, input int exp, input string req);
    int tm = 0;
    for (int i = 0; i < clocks; i++) begin
      @(negedge clk);
      if (tmr_en) tm++;
    end
    check(req, "timer pulses in window", tm, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state and startup clock
    repeat (2) @(negedge clk);
    check("R1", "phase in reset", int'(phase), 0);
    check("R1", "outputs in reset", int'({stall, fetch_en, tmr_en}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", "phase first clock", int'(phase), 0);
    check("R1", "outputs first clock", int'({stall, fetch_en, tmr_en}), 0);
    @(negedge clk);
    check("R2", "phase second clock", int'(phase), 1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].mode != cur_mode) do_reset(VECS[i].mode);
      run_vec(VECS[i]);
    end

    // R4: timer enable rate in steady state
    do_reset(1'b0);
    repeat (3) @(negedge clk);
    count_tmr(16, 8, "R4");
    do_reset(1'b1);
    repeat (3) @(negedge clk);
    count_tmr(16, 4, "R4");

    // R11: configuration change after startup is ignored
    do_reset(1'b0);
    repeat (3) @(negedge clk);
    cfg = 1'b1;
    run_vec('{1'b0, 5'b00000, 1'b0, 4'd0, 5'd2});
    count_tmr(16, 8, "R11");
    do_reset(1'b1);
    repeat (3) @(negedge clk);
    cfg = 1'b0;
    count_tmr(16, 4, "R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule